// File: doc/BRIEF.md
# Hexadecimal Floating-Point Adder/Subtractor

This unit adds or subtracts two 32-bit base-16 floating-point words. It returns a packed result and three condition flags: less, greater and overflow. Each word has a sign in bit 31, a 7-bit excess-64 exponent (a power of sixteen) in bits 30..24, and a six-hex-digit fraction in bits 23..0. Both operands are normalized first, one hex digit per cycle. The unit then orders them by magnitude and aligns the smaller one into a 56-bit fraction. The low 32 bits of that fraction act as a guard extension. It then adds or subtracts, renormalizes digit by digit, rounds, and packs the result. Underflow gives a clean zero. Overflow saturates.

Operands enter through a valid/ready handshake. `in_ready` is high only while the unit is idle. A transfer happens on a clock edge where both `in_valid` and `in_ready` are high. There is no back-pressure on the result side. The result word and the flags are written together. On the next cycle `out_done` pulses for one cycle. The result and flags then hold until the next operation is packed. The latency depends on the data: about 6 cycles for normalized inputs, and up to about 25 cycles when both the input and output normalizers run their longest.

Top module: `hfp_addsub`

## Requirements
- R1: `in_ready` is high after reset and whenever the unit is idle. After a transfer it stays low until the operation completes. `in_valid` and the operand inputs are ignored while it is low.
- R2: For every accepted operation, `out_done` is high for exactly one cycle. At that point the result and flags have already been written. They stay unchanged until the next operation completes.
- R3: Operands with leading zero hex digits are normalized before use. The fraction shifts left one digit and the exponent drops by one until the top digit (bits 23..20) is nonzero. Every nonzero result is normalized.
- R4: Subtraction inverts the sign of the second operand and then proceeds as an addition.
- R5: An operand with a zero fraction counts as zero whatever its sign and exponent. If the first operand is zero, the result is the normalized second operand (with its sign inverted for subtraction). If the second is zero, the result is the normalized first operand.
- R6: The operand of smaller magnitude is shifted right by four bits per digit of exponent difference. Magnitude is compared by exponent, then by fraction. A difference above 14 digits makes the smaller operand zero.
- R7: When the effective signs differ, the 56-bit fractions are subtracted with borrow through the extension, and the result is renormalized. Equal magnitudes give the word 0x00000000 with no flags.
- R8: When the signs match and the fraction sum carries out of bit 23, the fraction shifts right one digit and the exponent increments.
- R9: If bit 31 of the extension is set, 1 is added to the 24-bit fraction. A carry out of that addition shifts the fraction right one digit and increments the exponent.
- R10: A nonzero result whose exponent ends at 0 or below is stored as 0x00000000, with overflow set and neither less nor greater.
- R11: A result exponent above 127 stores the sign followed by 31 ones (0x7FFFFFFF or 0xFFFFFFFF). Overflow is set, plus less for a negative sign or greater for a positive one.
- R12: A negative in-range result raises less, a positive nonzero result raises greater, and a zero result raises neither. The flags are encoded {lt,gt,ovf}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and select are offered |
| in_ready | output | 1 | Unit is idle and accepts operands |
| in_a | input | 32 | First operand word |
| in_b | input | 32 | Second operand word |
| in_sub | input | 1 | 1 selects a minus b, 0 selects a plus b |
| out_done | output | 1 | One-cycle completion pulse |
| out_result | output | 32 | Packed result word |
| out_lt | output | 1 | Result is negative |
| out_gt | output | 1 | Result is positive and nonzero |
| out_ovf | output | 1 | Exponent underflow or overflow |

## Verification
The bound assertions check, on every cycle, that `in_ready` drops after a transfer, that `out_done` is a single pulse followed by the idle state, and that the result is stable while idle. At each completion they also check that the flags agree with the sign and value of the result word, that any zero is a clean zero, that nonzero results are normalized, and that overflow yields either a clean zero or a saturated word. Only the bench's operand vectors can show that the arithmetic is right. That covers digit alignment and the 14-digit cutoff, borrow through the extension, carry renormalization, rounding (including a rounding carry that pushes into overflow), operand swap by magnitude, and zero pass-through. Ignoring a second offer while busy is also shown by a directed scenario.

// File: rtl/hfp_pkg.sv
package hfp_pkg;
  localparam int FRAC_W    = 24;
  localparam int EXP_W     = 7;
  localparam int EXT_W     = 32;
  localparam int DIG       = 4;
  localparam int MAX_ALIGN = 14;
  localparam int EI_W      = 10;
  localparam int ACC_W     = FRAC_W + EXT_W;
  localparam int WORD_W    = 1 + EXP_W + FRAC_W;
  localparam int LOG_DIG   = $clog2(DIG);
  localparam int SH_W      = $clog2(MAX_ALIGN * DIG + 1);

  typedef logic signed [EI_W-1:0] exp_t;

  localparam exp_t EXP_LIM = exp_t'((1 << EXP_W) - 1);

  typedef struct packed {
    logic                sign;
    exp_t                exp;
    logic [ACC_W-1:0]    frac;
  } ufp_t;

  typedef enum logic [2:0] {
    S_IDLE, S_NORM, S_ALIGN, S_SUM, S_RENORM, S_PACK, S_DONE
  } state_t;
endpackage

// File: rtl/hfp_digit_norm.sv
module hfp_digit_norm
  import hfp_pkg::*;
#(
  parameter int W = 56
) (
  input  logic [W-1:0] frac_i,
  input  exp_t         exp_i,
  output logic [W-1:0] frac_o,
  output exp_t         exp_o,
  output logic         is_norm,
  output logic         is_zero
);
  always_comb begin
    frac_o  = frac_i << DIG;
    exp_o   = exp_i - exp_t'(1);
    is_norm = |frac_i[W-1 -: DIG];
    is_zero = ~|frac_i;
  end
endmodule

// File: rtl/hfp_align.sv
module hfp_align
  import hfp_pkg::*;
(
  input  ufp_t             a_i,
  input  ufp_t             b_i,
  input  logic             sub_i,
  output ufp_t             big_o,
  output logic [ACC_W-1:0] small_o,
  output logic             eff_sub_o
);
  logic a_zero, b_zero, b_sign, a_less, swap, sm_sign;
  exp_t ea, eb, sm_e;
  logic [ACC_W-1:0] sm_frac;
  logic signed [EI_W:0] ediff;
  logic [SH_W-1:0] shamt;

  always_comb begin
    ea      = a_i.exp;
    eb      = b_i.exp;
    a_zero  = ~|a_i.frac;
    b_zero  = ~|b_i.frac;
    b_sign  = b_i.sign ^ sub_i;
    a_less  = (ea < eb) || ((ea == eb) && (a_i.frac < b_i.frac));
    swap    = a_zero || (!b_zero && a_less);
    if (swap) begin
      big_o   = b_i;
      big_o.sign = b_sign;
      sm_frac = a_i.frac;
      sm_e    = ea;
      sm_sign = a_i.sign;
    end else begin
      big_o   = a_i;
      sm_frac = b_i.frac;
      sm_e    = eb;
      sm_sign = b_sign;
    end
    ediff = (EI_W+1)'(big_o.exp) - (EI_W+1)'(sm_e);
    shamt = SH_W'(ediff) << LOG_DIG;
    if (ediff > MAX_ALIGN) small_o = '0;
    else                   small_o = sm_frac >> shamt;
    eff_sub_o = big_o.sign ^ sm_sign;
  end
endmodule

// File: rtl/hfp_pack.sv
module hfp_pack
  import hfp_pkg::*;
(
  input  ufp_t              v_i,
  output logic [WORD_W-1:0] word_o,
  output logic              lt_o,
  output logic              gt_o,
  output logic              ovf_o
);
  logic [FRAC_W:0]   rsum;
  logic [FRAC_W-1:0] fr;
  exp_t              e;

  always_comb begin
    rsum = {1'b0, v_i.frac[ACC_W-1 -: FRAC_W]} + (FRAC_W+1)'(v_i.frac[EXT_W-1]);
    if (rsum[FRAC_W]) begin
      fr = FRAC_W'(rsum >> DIG);
      e  = v_i.exp + exp_t'(1);
    end else begin
      fr = rsum[FRAC_W-1:0];
      e  = v_i.exp;
    end
    word_o = '0;
    lt_o   = 1'b0;
    gt_o   = 1'b0;
    ovf_o  = 1'b0;
    if (fr == '0) begin
      word_o = '0;
    end else if (e <= exp_t'(0)) begin
      ovf_o = 1'b1;
    end else if (e > EXP_LIM) begin
      ovf_o  = 1'b1;
      lt_o   = v_i.sign;
      gt_o   = !v_i.sign;
      word_o = {v_i.sign, {(WORD_W-1){1'b1}}};
    end else begin
      word_o = {v_i.sign, e[EXP_W-1:0], fr};
      lt_o   = v_i.sign;
      gt_o   = !v_i.sign;
    end
  end
endmodule

// File: rtl/hfp_addsub.sv
module hfp_addsub
  import hfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  input  logic              in_sub,
  output logic              out_done,
  output logic [WORD_W-1:0] out_result,
  output logic              out_lt,
  output logic              out_gt,
  output logic              out_ovf
);
  state_t st;
  ufp_t   ra, rb, big;
  logic   sub_q, eff_q, eff_sub;

  logic [ACC_W-1:0] na_frac, nb_frac, small_frac;
  exp_t             na_exp, nb_exp;
  logic             na_norm, na_zero, nb_norm, nb_zero;
  logic [ACC_W:0]   sum_w;
  logic [WORD_W-1:0] pk_word;
  logic             pk_lt, pk_gt, pk_ovf;

  function automatic ufp_t unpack(input logic [WORD_W-1:0] w);
    ufp_t u;
    u.sign = w[WORD_W-1];
    u.exp  = '0;
    u.exp[EXP_W-1:0] = w[WORD_W-2 -: EXP_W];
    u.frac = {w[FRAC_W-1:0], {EXT_W{1'b0}}};
    return u;
  endfunction

  hfp_digit_norm #(.W(ACC_W)) u_norm_a (
    .frac_i(ra.frac), .exp_i(ra.exp), .frac_o(na_frac), .exp_o(na_exp),
    .is_norm(na_norm), .is_zero(na_zero));

  hfp_digit_norm #(.W(ACC_W)) u_norm_b (
    .frac_i(rb.frac), .exp_i(rb.exp), .frac_o(nb_frac), .exp_o(nb_exp),
    .is_norm(nb_norm), .is_zero(nb_zero));

  hfp_align u_align (
    .a_i(ra), .b_i(rb), .sub_i(sub_q),
    .big_o(big), .small_o(small_frac), .eff_sub_o(eff_sub));

  hfp_pack u_pack (
    .v_i(ra), .word_o(pk_word), .lt_o(pk_lt), .gt_o(pk_gt), .ovf_o(pk_ovf));

  always_comb begin
    if (eff_q) sum_w = {1'b0, ra.frac} - {1'b0, rb.frac};
    else       sum_w = {1'b0, ra.frac} + {1'b0, rb.frac};
  end

  assign in_ready = (st == S_IDLE);
  assign out_done = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      ra         <= '0;
      rb         <= '0;
      sub_q      <= 1'b0;
      eff_q      <= 1'b0;
      out_result <= '0;
      out_lt     <= 1'b0;
      out_gt     <= 1'b0;
      out_ovf    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (in_valid) begin
          ra    <= unpack(in_a);
          rb    <= unpack(in_b);
          sub_q <= in_sub;
          st    <= S_NORM;
        end
        S_NORM: begin
          if (na_zero) begin
            ra.sign <= 1'b0;
            ra.exp  <= '0;
          end else if (!na_norm) begin
            ra.frac <= na_frac;
            ra.exp  <= na_exp;
          end
          if (nb_zero) begin
            rb.sign <= 1'b0;
            rb.exp  <= '0;
          end else if (!nb_norm) begin
            rb.frac <= nb_frac;
            rb.exp  <= nb_exp;
          end
          if ((na_zero || na_norm) && (nb_zero || nb_norm)) st <= S_ALIGN;
        end
        S_ALIGN: begin
          ra      <= big;
          rb.frac <= small_frac;
          eff_q   <= eff_sub;
          st      <= S_SUM;
        end
        S_SUM: begin
          if (sum_w[ACC_W]) begin
            ra.frac <= ACC_W'(sum_w >> DIG);
            ra.exp  <= ra.exp + exp_t'(1);
          end else begin
            ra.frac <= sum_w[ACC_W-1:0];
          end
          st <= S_RENORM;
        end
        S_RENORM: begin
          if (na_zero) begin
            ra.sign <= 1'b0;
            ra.exp  <= '0;
            st      <= S_PACK;
          end else if (na_norm) begin
            st <= S_PACK;
          end else begin
            ra.frac <= na_frac;
            ra.exp  <= na_exp;
          end
        end
        S_PACK: begin
          out_result <= pk_word;
          out_lt     <= pk_lt;
          out_gt     <= pk_gt;
          out_ovf    <= pk_ovf;
          st         <= S_DONE;
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hfp_addsub_chk.sv
module hfp_addsub_chk
  import hfp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_done,
  input logic [WORD_W-1:0] out_result,
  input logic              out_lt,
  input logic              out_gt,
  input logic              out_ovf
);
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R1

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> !out_done); // R2

  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> in_ready); // R2

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> ($stable(out_result) && $stable(out_lt) && $stable(out_gt) && $stable(out_ovf))); // R2

  AST_RESULT_NORMALIZED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && out_result != '0 && !(out_ovf && (out_lt || out_gt)))
      |-> (out_result[FRAC_W-1 -: DIG] != '0)); // R3

  AST_CLEAN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && out_result[FRAC_W-1:0] == '0) |-> (out_result == '0)); // R7

  AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && out_ovf && !out_lt && !out_gt) |-> (out_result == '0)); // R10

  AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && out_ovf && (out_lt || out_gt))
      |-> (out_result[WORD_W-2:0] == {(WORD_W-1){1'b1}} && out_result[WORD_W-1] == out_lt)); // R11

  AST_FLAG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> !(out_lt && out_gt)); // R12

  AST_FLAG_BY_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && !out_ovf)
      |-> (out_lt == out_result[WORD_W-1] &&
           out_gt == (out_result != '0 && !out_result[WORD_W-1]))); // R12
endmodule

bind hfp_addsub hfp_addsub_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_done(out_done), .out_result(out_result), .out_lt(out_lt),
  .out_gt(out_gt), .out_ovf(out_ovf));

// File: tb/hfp_addsub_tb.sv
`timescale 1ns/1ps
module hfp_addsub_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0, in_b = '0;
  logic        in_sub = 1'b0;
  logic        out_done;
  logic [31:0] out_result;
  logic        out_lt, out_gt, out_ovf;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  hfp_addsub u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_sub(in_sub), .out_done(out_done),
    .out_result(out_result), .out_lt(out_lt), .out_gt(out_gt), .out_ovf(out_ovf));

  // {a, b, sub, expected result, expected {lt,gt,ovf}}
  localparam int NV = 24;
  localparam logic [99:0] VEC [NV] = '{
    {32'h41100000, 32'h41100000, 1'b0, 32'h41200000, 3'b010}, // R8 plain add
    {32'h41800000, 32'h41800000, 1'b0, 32'h42100000, 3'b010}, // R8 carry out
    {32'h41100000, 32'h41100000, 1'b1, 32'h00000000, 3'b000}, // R7 equal cancel
    {32'h41100000, 32'h41200000, 1'b1, 32'hC1100000, 3'b100}, // R4 sign flip
    {32'h41100000, 32'h3A100000, 1'b1, 32'h41100000, 3'b010}, // R7 borrow into ext, R9
    {32'h41100000, 32'h3B800000, 1'b0, 32'h41100001, 3'b010}, // R9 round up
    {32'h41100000, 32'h3B700000, 1'b0, 32'h41100000, 3'b010}, // R9 no round
    {32'h41100000, 32'h30800000, 1'b0, 32'h41100000, 3'b010}, // R6 beyond 14 digits
    {32'h41100000, 32'h30800000, 1'b1, 32'h41100000, 3'b010}, // R6 beyond 14 digits sub
    {32'h00000000, 32'hC2123456, 1'b0, 32'hC2123456, 3'b100}, // R5 a zero
    {32'h80000000, 32'h42123456, 1'b1, 32'hC2123456, 3'b100}, // R5 a zero, sub
    {32'h42123456, 32'h7F000000, 1'b0, 32'h42123456, 3'b010}, // R5 b zero frac
    {32'h00000000, 32'h42012345, 1'b0, 32'h41123450, 3'b010}, // R3 normalize b
    {32'h43000100, 32'h40100000, 1'b0, 32'h40200000, 3'b010}, // R3 normalize a
    {32'h00100000, 32'h00000000, 1'b0, 32'h00000000, 3'b001}, // R10 exp zero
    {32'h01110000, 32'h01100000, 1'b1, 32'h00000000, 3'b001}, // R10 after renorm
    {32'h7F800000, 32'h7F800000, 1'b0, 32'h7FFFFFFF, 3'b011}, // R11 positive
    {32'hFF800000, 32'hFF800000, 1'b0, 32'hFFFFFFFF, 3'b101}, // R11 negative
    {32'h7FFFFFFF, 32'h79800000, 1'b0, 32'h7FFFFFFF, 3'b011}, // R11 via rounding R9
    {32'h7F100000, 32'h7F100000, 1'b0, 32'h7F200000, 3'b010}, // R11 top exponent ok
    {32'hC1100000, 32'h41300000, 1'b0, 32'h41200000, 3'b010}, // R12 swap, positive
    {32'h42100000, 32'hC2180000, 1'b0, 32'hC1800000, 3'b100}, // R12 fraction order
    {32'h00000000, 32'h00000000, 1'b0, 32'h00000000, 3'b000}, // R12 zero
    {32'h80000000, 32'h00000000, 1'b1, 32'h00000000, 3'b000}  // R12 zero sub
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  // Offer one operation, wait for done; returns result and flags sampled at done.
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic sub,
                        output logic [31:0] res, output logic [2:0] fl, output int done_w);
    int wait_n;
    @(negedge clk);
    in_a = a; in_b = b; in_sub = sub; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    wait_n = 0;
    while (!out_done && wait_n < 200) begin
      @(negedge clk);
      wait_n++;
    end
    res = out_result;
    fl  = {out_lt, out_gt, out_ovf};
    done_w = 0;
    while (out_done && done_w < 5) begin
      @(negedge clk);
      done_w++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] res;
    logic [2:0]  fl;
    int          dw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("R1 ready after reset", {31'b0, in_ready}, 32'd1);
    check("R2 no done after reset", {31'b0, out_done}, 32'd0);
    check("R2 result after reset", out_result, 32'h0);
    check("R12 flags after reset", {29'b0, out_lt, out_gt, out_ovf}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [99:0] v;
      v = VEC[i];
      run_op(v[99:68], v[67:36], v[35], res, fl, dw);
      check($sformatf("R7 R9 R12 vector %0d result", i), res, v[34:3]);
      check($sformatf("R10 R11 R12 vector %0d flags", i), {29'b0, fl}, {29'b0, v[2:0]});
      check($sformatf("R2 vector %0d done width", i), dw, 32'd1);
    end

    // R1: a second offer while busy is ignored
    @(negedge clk);
    in_a = 32'h41100000; in_b = 32'h41100000; in_sub = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_a = 32'h7F800000; in_b = 32'h7F800000;
    check("R1 ready low while busy", {31'b0, in_ready}, 32'd0);
    begin
      int w;
      w = 0;
      while (!out_done && w < 200) begin
        @(negedge clk);
        w++;
      end
    end
    in_valid = 1'b0;
    check("R1 busy offer ignored, result", out_result, 32'h41200000);
    check("R1 busy offer ignored, flags", {29'b0, out_lt, out_gt, out_ovf}, 32'b010);
    begin
      int extra;
      extra = 0;
      repeat (12) begin
        @(negedge clk);
        if (out_done) extra++;
      end
      check("R1 no extra completion", extra, 32'd0);
    end
    // R2: result holds while idle
    check("R2 result held", out_result, 32'h41200000);
    check("R1 ready when idle", {31'b0, in_ready}, 32'd1);

    summary();
    $finish;
  end
endmodule